// File: doc/BRIEF.md
# Programmable Accumulator Word Selector

This block reduces a wide signed filter accumulator to a 16-bit signed sample. A run-time select value says how many most-significant bits to throw away. The next 16 bits form the output word. The bits below that word are removed with round-half-to-even rounding.

When the discarded upper bits are not a plain sign extension of the chosen word, the result is clamped to the nearest 16-bit signed limit. The result is also clamped when rounding pushes the word past the largest positive value. Either case sets a sticky overflow flag, which software reads while it searches for a select value that fits the signal level.

The block has one register stage. Each accumulator accepted with its valid strobe gives one registered word, with the matching valid strobe, on the next cycle.

Top module: `acc_word_sel`

## Requirements
- R1: With select value s (0 to 22), the output word is accumulator bits [37-s : 22-s], taken from a 38-bit two's-complement input. When the bits below the window are zero and no saturation applies, the word is copied unchanged.
- R2: A select value above 22 gives the same result as a select value of 22.
- R3: The bits below the window are rounded by value. Below half rounds down and above half rounds up. Exactly half rounds to the even word, so it rounds up only when word bit 0 is 1.
- R4: If any discarded upper bit differs from the window's top bit, the output is 0x7FFF when accumulator bit 37 is 0 and 0x8000 when it is 1.
- R5: If rounding would carry a window of 0x7FFF upward, the output stays at 0x7FFF.
- R6: Whenever R4 or R5 saturates a result, the overflow flag is 1 in the same cycle that the saturated word is first presented.
- R7: The overflow flag stays set until a clear pulse. A clear pulse in a cycle with no new overflow drops the flag on the next cycle. A new overflow in the same cycle as a clear pulse leaves the flag set.
- R8: The output valid strobe is the input valid strobe delayed by exactly one clock.
- R9: When the input valid strobe is low, the output word and the overflow flag (apart from a clear pulse) do not change.
- R10: After reset the output word is 0x0000, and the output valid strobe and the overflow flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 38 | Signed accumulator value |
| acc_vld_i | input | 1 | Accumulator valid strobe |
| sel_i | input | 5 | Count of MSBs to discard |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| word_o | output | 16 | Rounded, saturated signed word |
| word_vld_o | output | 1 | Output valid strobe |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that every input is driven to a known level whenever reset is released. They also assume that the clear pulse and the valid strobe are sampled only on clock edges. The bench meets this by changing inputs only on falling edges and by keeping every input at 0 while no vector is applied.

The vectors use select values both inside the legal range and above it. This checks that the clamped select value feeds the window, the range check and the rounding in the same way.

// File: rtl/acc_sel_pkg.sv
package acc_sel_pkg;
  localparam int unsigned ACC_W_DEF = 38;
  localparam int unsigned OUT_W_DEF = 16;
  localparam int unsigned SEL_W_DEF = 5;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_POS  = 2'd1,
    SAT_NEG  = 2'd2
  } sat_kind_e;
endpackage

// File: rtl/acc_sel_clamp.sv
module acc_sel_clamp #(
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned MAX_SHIFT = 22
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] shift_o
);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_SHIFT);

  always_comb begin
    if (sel_i > MAX_SEL) shift_o = MAX_SEL;
    else                 shift_o = sel_i;
  end
endmodule

// File: rtl/acc_sel_align.sv
module acc_sel_align #(
  parameter int unsigned ACC_W = 38,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SEL_W = 5
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SEL_W-1:0] shift_i,
  output logic [OUT_W-1:0] win_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic             range_bad_o
);
  localparam int unsigned LOW_W = ACC_W - OUT_W;
  localparam int unsigned AMT_W = $clog2(ACC_W) + 1;

  logic [ACC_W-1:0]        shl;
  logic signed [ACC_W-1:0] sar;
  logic [AMT_W-1:0]        amt;

  // left-align window so rounding/guard positions are fixed
  assign shl      = acc_i << shift_i;
  assign win_o    = shl[ACC_W-1 -: OUT_W];
  assign guard_o  = shl[LOW_W-1];
  assign sticky_o = |shl[LOW_W-2:0];

  // discarded MSBs plus window sign must all match
  assign amt         = AMT_W'(ACC_W - 1) - AMT_W'(shift_i);
  assign sar         = $signed(acc_i) >>> amt;
  assign range_bad_o = !((&sar) || (~|sar));
endmodule

// File: rtl/acc_sel_round.sv
module acc_sel_round
  import acc_sel_pkg::*;
#(
  parameter int unsigned OUT_W = 16
) (
  input  logic [OUT_W-1:0] win_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             range_bad_i,
  input  logic             sign_i,
  output logic [OUT_W-1:0] word_o,
  output logic             ovf_o,
  output sat_kind_e        sat_o
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic up;
  assign up = guard_i & (sticky_i | win_i[0]);

  always_comb begin
    sat_o = SAT_NONE;
    if (range_bad_i)               sat_o = sign_i ? SAT_NEG : SAT_POS;
    else if (up && win_i == POS_MAX) sat_o = SAT_POS;
  end

  always_comb begin
    unique case (sat_o)
      SAT_POS: word_o = POS_MAX;
      SAT_NEG: word_o = NEG_MIN;
      default: word_o = win_i + OUT_W'(up);
    endcase
    ovf_o = (sat_o != SAT_NONE);
  end
endmodule

// File: rtl/acc_word_sel.sv
module acc_word_sel
  import acc_sel_pkg::*;
#(
  parameter int unsigned ACC_W = ACC_W_DEF,
  parameter int unsigned OUT_W = OUT_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             acc_vld_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ovf_clr_i,
  output logic [OUT_W-1:0] word_o,
  output logic             word_vld_o,
  output logic             ovf_o
);
  localparam int unsigned MAX_SHIFT = ACC_W - OUT_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [SEL_W-1:0] shift;
  logic [OUT_W-1:0] win, rnd_word;
  logic             guard, sticky, range_bad, rnd_ovf;
  sat_kind_e        sat;

  logic [OUT_W-1:0] word_q;
  logic             vld_q, ovf_q;

  acc_sel_clamp #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_clamp (
    .sel_i   (sel_i),
    .shift_o (shift)
  );

  acc_sel_align #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_align (
    .acc_i       (acc_i),
    .shift_i     (shift),
    .win_o       (win),
    .guard_o     (guard),
    .sticky_o    (sticky),
    .range_bad_o (range_bad)
  );

  acc_sel_round #(.OUT_W(OUT_W)) u_round (
    .win_i       (win),
    .guard_i     (guard),
    .sticky_i    (sticky),
    .range_bad_i (range_bad),
    .sign_i      (acc_i[ACC_W-1]),
    .word_o      (rnd_word),
    .ovf_o       (rnd_ovf),
    .sat_o       (sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      vld_q <= acc_vld_i;
      if (acc_vld_i) word_q <= rnd_word;
      // new overflow beats a simultaneous clear
      if (acc_vld_i && rnd_ovf) ovf_q <= 1'b1;
      else if (ovf_clr_i)       ovf_q <= 1'b0;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign ovf_o      = ovf_q;

  assert_vld_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i |=> word_vld_o);
  assert_vld_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_i |=> !word_vld_o);
  assert_word_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_i |=> $stable(word_o));
  assert_sat_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && sat != SAT_NONE) |=> (ovf_o && (word_o == POS_MAX || word_o == NEG_MIN)));
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !acc_vld_i) |=> !ovf_o);
endmodule

// File: tb/acc_word_sel_tb.sv
`timescale 1ns/1ps
module acc_word_sel_tb;
  localparam int NV = 18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [37:0] acc_i = '0;
  logic        acc_vld_i = 1'b0;
  logic [4:0]  sel_i = '0;
  logic        ovf_clr_i = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o, ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_word_sel u_dut (
    .clk_i, .rst_ni, .acc_i, .acc_vld_i, .sel_i, .ovf_clr_i,
    .word_o, .word_vld_o, .ovf_o
  );

  localparam logic [37:0] V_ACC [NV] = '{
    {16'h1234, 22'h0},
    {22'h0, 16'h0ABC},
    {22'h3FFFFF, 16'h8001},
    {22'h000001, 16'h1234},
    {22'h0, 16'h8000},
    {16'h0010, 1'b1, 21'h0},
    {16'h0011, 1'b1, 21'h0},
    {16'h0010, 1'b1, 21'h1},
    {16'h0010, 1'b0, 21'h1FFFFF},
    {16'h7FFF, 1'b1, 21'h1},
    {16'h7FFF, 1'b1, 21'h0},
    {16'hFFFF, 1'b1, 21'h0},
    {16'h8000, 1'b1, 21'h0},
    {4'h0, 16'h4321, 18'h0},
    {4'hE, 16'h4321, 18'h0},
    {22'h0, 16'h0ABC},
    {36'h0, 2'b11},
    {10'h0, 16'h0005, 1'b1, 11'h0}
  };
  localparam logic [4:0] V_SEL [NV] = '{
    5'd0, 5'd22, 5'd22, 5'd22, 5'd22, 5'd0, 5'd0, 5'd0, 5'd0,
    5'd0, 5'd0, 5'd0, 5'd0, 5'd4, 5'd4, 5'd31, 5'd31, 5'd10
  };
  localparam logic [15:0] V_WORD [NV] = '{
    16'h1234, 16'h0ABC, 16'h8001, 16'h7FFF, 16'h7FFF, 16'h0010,
    16'h0012, 16'h0011, 16'h0010, 16'h7FFF, 16'h7FFF, 16'h0000,
    16'h8000, 16'h4321, 16'h8000, 16'h0ABC, 16'h0003, 16'h0006
  };
  localparam logic V_OVF [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample one cycle later on falling edge
  task automatic apply(logic [37:0] acc, logic [4:0] sel, logic clr);
    @(negedge clk_i);
    acc_i = acc; sel_i = sel; acc_vld_i = 1'b1; ovf_clr_i = clr;
    @(negedge clk_i);
    acc_i = '0; sel_i = '0; acc_vld_i = 1'b0; ovf_clr_i = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk_i);
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 word", word_o, 16'h0000);
    check("R10 vld", {15'h0, word_vld_o}, 16'h0);
    check("R10 ovf", {15'h0, ovf_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      clear_flag();
      apply(V_ACC[i], V_SEL[i], 1'b0);
      check("table R1 R2 R3 R4 R5 word", word_o, V_WORD[i]);
      check("table R6 ovf", {15'h0, ovf_o}, {15'h0, V_OVF[i]});
      check("R8 vld high", {15'h0, word_vld_o}, 16'h1);
      @(negedge clk_i);
      check("R8 vld low", {15'h0, word_vld_o}, 16'h0);
    end

    // R9 hold while valid low, even with changing inputs
    clear_flag();
    apply({16'h2468, 22'h0}, 5'd0, 1'b0);
    @(negedge clk_i);
    acc_i = {22'h000001, 16'h1234}; sel_i = 5'd22;
    repeat (3) @(negedge clk_i);
    check("R9 word held", word_o, 16'h2468);
    check("R9 ovf untouched", {15'h0, ovf_o}, 16'h0);
    acc_i = '0; sel_i = '0;

    // R7 sticky across a clean vector
    apply({22'h000001, 16'h1234}, 5'd22, 1'b0);
    check("R6 flag with sat", {15'h0, ovf_o}, 16'h1);
    apply({16'h0100, 22'h0}, 5'd0, 1'b0);
    check("R7 sticky", {15'h0, ovf_o}, 16'h1);
    check("R7 clean word", word_o, 16'h0100);
    repeat (2) @(negedge clk_i);
    check("R7 sticky idle", {15'h0, ovf_o}, 16'h1);
    clear_flag();
    check("R7 cleared", {15'h0, ovf_o}, 16'h0);

    // R7 set beats clear in the same cycle
    apply({4'hE, 16'h4321, 18'h0}, 5'd4, 1'b1);
    check("R7 set wins", {15'h0, ovf_o}, 16'h1);
    check("R4 neg sat", word_o, 16'h8000);

    // R7 clear with clean vector drops flag
    apply({16'h0042, 22'h0}, 5'd0, 1'b1);
    check("R7 clear with clean vld", {15'h0, ovf_o}, 16'h0);
    check("R1 word", word_o, 16'h0042);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule